// File: doc/BRIEF.md
# Overlapped TLB and Physically Tagged Data Cache Lookup

This block is the read path of a small direct-mapped data cache whose set index is taken from bits of the address that translation never changes. When a read is accepted, the cache array is read with the page-offset index in the same cycle that the virtual page number goes out to an external TLB. In the next cycle the translated physical page number is compared with the tag stored in the indexed line. The hit decision therefore needs both results: a successful translation and a tag match.

A lookup whose translation arrives in the first cycle and whose tag matches returns its word one cycle after the request. If translation succeeds but the line is invalid or holds another physical page, the block fetches the word from memory at the translated address. It then writes the line and completes the read with the fetched word. If the TLB answers late, the comparison waits for it. If the TLB reports a fault, the read ends with an error flag, and the cache is left as it was. Each way can be no larger than a page, because the index has to stay inside the page offset.

Top module: `ptag_dcache`

## Requirements
- R1: After reset, `busy_o`, `rsp_valid_o`, `rsp_err_o` and `mem_req_o` are low, and every line is invalid, so the first read of any address goes to memory.
- R2: A read is accepted when `req_valid_i` is high and the block is idle. In that cycle `tlb_req_o` is high and `tlb_vpn_o` equals `req_vaddr_i[31:12]`. The line index is `req_vaddr_i[11:2]`.
- R3: If `tlb_done_i` is high without `tlb_fault_i` in the cycle after acceptance, and the indexed line is valid with a tag equal to `tlb_ppn_i`, then `rsp_valid_o` is high in that cycle with the stored word, and no memory request is made.
- R4: If translation succeeds but the line is invalid or its tag differs, `mem_req_o` is raised in the next cycle with `mem_paddr_o = {ppn, index, 2'b00}`. It is held, with the address stable, until `mem_ack_i`.
- R5: In the `mem_ack_i` cycle, `rsp_valid_o` is high with `rsp_data_o = mem_rdata_i`, and the line takes that word and tag. Later reads of the same physical word hit and return it even if memory has changed.
- R6: If `tlb_done_i` arrives later than the first cycle, the hit or miss decision is made in the cycle it arrives, using the line read at acceptance.
- R7: `tlb_done_i` with `tlb_fault_i` ends the read with `rsp_err_o` high and `rsp_valid_o` low. No memory request follows, and no line is changed.
- R8: `busy_o` is high in every cycle after acceptance that has no response, and low in the response cycle. No request is accepted while busy (`tlb_req_o` stays low).
- R9: Lines are tagged physically. Two virtual pages that translate to the same physical page share lines, and the byte-select bits `[1:0]` have no effect on the lookup.
- R10: `rsp_valid_o` and `rsp_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request |
| req_vaddr_i | input | 32 | Virtual byte address |
| tlb_req_o | output | 1 | TLB lookup strobe, high when a read is accepted |
| tlb_vpn_o | output | 20 | Virtual page number sent to the TLB |
| tlb_done_i | input | 1 | TLB result present this cycle |
| tlb_fault_i | input | 1 | TLB result is a fault |
| tlb_ppn_i | input | 20 | Translated physical page number |
| mem_req_o | output | 1 | Line-fill memory request |
| mem_paddr_o | output | 32 | Physical word address of the fill |
| mem_ack_i | input | 1 | Fill data present |
| mem_rdata_i | input | 32 | Fill data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Read ended by translation fault |
| busy_o | output | 1 | Read in flight without a result yet |

## Verification
The checker watches four things on every cycle:
- Data and error responses never coincide.
- An error response appears only together with a faulting translation.
- A pending fill keeps its request and physical address stable.
- Busy blocks new lookups, and every lookup is followed by either busy or a response.

Only the bench scenarios can show the behaviour that depends on history. That covers whether a line really matched after a refill, that a fault leaves a valid line untouched, that two virtual pages share a physical line, and the exact latency on each path.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_XLATE  = 2'd2,
    ST_FILL   = 2'd3
  } ptag_state_e;
endpackage

// File: rtl/ptag_array.sv
module ptag_array #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   valid_q[g] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     valid_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  // read port is registered so it overlaps the TLB cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_tag_o   <= '0;
      rd_data_o  <= '0;
    end else if (rd_en_i) begin
      rd_valid_o <= valid_q[rd_idx_i];
      rd_tag_o   <= tag_mem[rd_idx_i];
      rd_data_o  <= data_mem[rd_idx_i];
    end
  end
endmodule

// File: rtl/ptag_tag_cmp.sv
module ptag_tag_cmp #(
  parameter int TAG_W = 20
) (
  input  logic             line_valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic [TAG_W-1:0] ppn_i,
  output logic             hit_o
);
  assign hit_o = line_valid_i && (line_tag_i == ppn_i);
endmodule

// File: rtl/ptag_ctrl.sv
module ptag_ctrl
  import ptag_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             tlb_done_i,
  input  logic             tlb_fault_i,
  input  logic [PPN_W-1:0] tlb_ppn_i,
  input  logic             line_hit_i,
  input  logic             mem_ack_i,
  output logic             accept_o,
  output logic             fill_o,
  output logic             rsp_hit_o,
  output logic             rsp_fill_o,
  output logic             rsp_err_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_q_o,
  output logic [PPN_W-1:0] ppn_q_o
);
  ptag_state_e st_q, st_d;
  logic xl_done, go_fill;

  assign accept_o   = req_valid_i && (st_q == ST_IDLE);
  assign xl_done    = tlb_done_i && (st_q == ST_LOOKUP || st_q == ST_XLATE);
  assign rsp_err_o  = xl_done && tlb_fault_i;
  assign rsp_hit_o  = xl_done && !tlb_fault_i && line_hit_i;
  assign go_fill    = xl_done && !tlb_fault_i && !line_hit_i;
  assign fill_o     = (st_q == ST_FILL);
  assign rsp_fill_o = fill_o && mem_ack_i;
  assign busy_o     = (st_q != ST_IDLE) && !(rsp_hit_o || rsp_fill_o || rsp_err_o);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept_o) st_d = ST_LOOKUP;
      ST_LOOKUP: st_d = xl_done ? (go_fill ? ST_FILL : ST_IDLE) : ST_XLATE;
      ST_XLATE:  if (xl_done) st_d = go_fill ? ST_FILL : ST_IDLE;
      ST_FILL:   if (mem_ack_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q_o <= '0;
      ppn_q_o <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) idx_q_o <= req_idx_i;
      if (go_fill)  ppn_q_o <= tlb_ppn_i;
    end
  end
endmodule

// File: rtl/ptag_dcache.sv
module ptag_dcache #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PPN_W  = 20,
  parameter int IDX_W  = 10
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_valid_i,
  input  logic [VA_W-1:0]                       req_vaddr_i,
  output logic                                  tlb_req_o,
  output logic [VA_W-PAGE_W-1:0]                tlb_vpn_o,
  input  logic                                  tlb_done_i,
  input  logic                                  tlb_fault_i,
  input  logic [PPN_W-1:0]                      tlb_ppn_i,
  output logic                                  mem_req_o,
  output logic [PPN_W+PAGE_W-1:0]               mem_paddr_o,
  input  logic                                  mem_ack_i,
  input  logic [(8<<(PAGE_W-IDX_W))-1:0]        mem_rdata_i,
  output logic                                  rsp_valid_o,
  output logic [(8<<(PAGE_W-IDX_W))-1:0]        rsp_data_o,
  output logic                                  rsp_err_o,
  output logic                                  busy_o
);
  localparam int BSEL_W = PAGE_W - IDX_W;
  localparam int DATA_W = 8 << BSEL_W;

  logic              accept, fill, rsp_hit, rsp_fill, line_hit;
  logic              line_valid;
  logic [PPN_W-1:0]  line_tag, ppn_q;
  logic [DATA_W-1:0] line_data;
  logic [IDX_W-1:0]  idx_q;

  // index lies wholly inside the page offset
  wire [IDX_W-1:0] req_idx = req_vaddr_i[PAGE_W-1:BSEL_W];

  ptag_ctrl #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i,
    .req_idx_i  (req_idx),
    .tlb_done_i, .tlb_fault_i, .tlb_ppn_i,
    .line_hit_i (line_hit),
    .mem_ack_i,
    .accept_o   (accept),
    .fill_o     (fill),
    .rsp_hit_o  (rsp_hit),
    .rsp_fill_o (rsp_fill),
    .rsp_err_o  (rsp_err_o),
    .busy_o     (busy_o),
    .idx_q_o    (idx_q),
    .ppn_q_o    (ppn_q)
  );

  ptag_array #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .rd_en_i    (accept),
    .rd_idx_i   (req_idx),
    .rd_valid_o (line_valid),
    .rd_tag_o   (line_tag),
    .rd_data_o  (line_data),
    .wr_en_i    (rsp_fill),
    .wr_idx_i   (idx_q),
    .wr_tag_i   (ppn_q),
    .wr_data_i  (mem_rdata_i)
  );

  ptag_tag_cmp #(.TAG_W(PPN_W)) u_cmp (
    .line_valid_i (line_valid),
    .line_tag_i   (line_tag),
    .ppn_i        (tlb_ppn_i),
    .hit_o        (line_hit)
  );

  assign tlb_req_o   = accept;
  assign tlb_vpn_o   = req_vaddr_i[VA_W-1:PAGE_W];
  assign mem_req_o   = fill;
  assign mem_paddr_o = {ppn_q, idx_q, {BSEL_W{1'b0}}};
  assign rsp_valid_o = rsp_hit || rsp_fill;
  assign rsp_data_o  = rsp_fill ? mem_rdata_i : line_data;
endmodule

// File: rtl/ptag_dcache_chk.sv
module ptag_dcache_chk #(
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            tlb_req_o,
  input logic            tlb_done_i,
  input logic            tlb_fault_i,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_paddr_o,
  input logic            mem_ack_i,
  input logic            rsp_valid_o,
  input logic            rsp_err_o,
  input logic            busy_o
);
  // R10
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_err_o));
  // R7
  err_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (tlb_done_i && tlb_fault_i && !mem_req_o));
  // R4
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_paddr_o)));
  // R8
  busy_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !tlb_req_o);
  // R8
  lookup_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o |=> (busy_o || rsp_valid_o || rsp_err_o));
  // R2
  lookup_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o |-> req_valid_i);
  // R3
  resp_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (!mem_req_o || mem_ack_i));
endmodule

bind ptag_dcache ptag_dcache_chk #(.PA_W(PPN_W + PAGE_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .tlb_req_o, .tlb_done_i, .tlb_fault_i,
  .mem_req_o, .mem_paddr_o, .mem_ack_i, .rsp_valid_o, .rsp_err_o, .busy_o
);

// File: tb/ptag_dcache_tb.sv
module ptag_dcache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        tlb_req;
  logic [19:0] tlb_vpn;
  logic        tlb_done = 1'b0, tlb_fault = 1'b0;
  logic [19:0] tlb_ppn = '0;
  logic        mem_req;
  logic [31:0] mem_paddr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_err, busy;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0, cyc_total = 0;
  logic [31:0] salt = 32'h0bad_f00d;

  always #2 clk = ~clk;

  ptag_dcache u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .tlb_req_o(tlb_req), .tlb_vpn_o(tlb_vpn), .tlb_done_i(tlb_done),
    .tlb_fault_i(tlb_fault), .tlb_ppn_i(tlb_ppn), .mem_req_o(mem_req),
    .mem_paddr_o(mem_paddr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err), .busy_o(busy)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] pa, input logic [31:0] s);
    return (pa * 32'h9e37_79b1) ^ s;
  endfunction

  function automatic logic [31:0] pa_of(input logic [19:0] ppn, input logic [31:0] va);
    return {ppn, va[11:2], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 20000);
      finish_run();
    end
  end

  // one read; TLB answers at cycle lat after acceptance, memory after mlat fill cycles
  task automatic read_op(input logic [31:0] va, input int lat, input bit flt,
                         input logic [19:0] ppn, input int mlat, input bit hold_req,
                         output bit got_v, output bit got_e, output logic [31:0] dat,
                         output int cyc, output bit used_mem);
    int mcnt = 0;
    bit done = 0;
    got_v = 0; got_e = 0; dat = '0; cyc = 0; used_mem = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    #1;
    chk(tlb_req && tlb_vpn == va[31:12], "R2", {tlb_req, 11'd0, tlb_vpn}, {1'b1, 11'd0, va[31:12]});
    @(negedge clk);
    req_valid = hold_req;
    for (int k = 1; k < 60 && !done; k++) begin
      cyc = k;
      tlb_done = (k == lat); tlb_fault = flt; tlb_ppn = ppn;
      if (mem_req) begin
        mcnt++;
        used_mem = 1;
        if (mcnt == 1) chk(mem_paddr == pa_of(ppn, va), "R4", mem_paddr, pa_of(ppn, va));
        mem_ack = (mcnt == mlat);
        mem_rdata = mem_word(mem_paddr, salt);
      end else mem_ack = 1'b0;
      #1;
      if (hold_req) chk(!tlb_req, "R8", tlb_req, 0);
      if (rsp_valid || rsp_err) begin
        got_v = rsp_valid; got_e = rsp_err; dat = rsp_data;
        chk(!busy, "R8", busy, 0);
        req_valid = 1'b0;
        done = 1;
      end else begin
        chk(busy, "R8", busy, 1);
        @(negedge clk);
      end
    end
    chk(done, "R8", done, 1);
    @(negedge clk);
    tlb_done = 0; tlb_fault = 0; mem_ack = 0; req_valid = 0;
  endtask

  task automatic test_reset();
    #1;
    chk(!busy && !rsp_valid && !rsp_err && !mem_req, "R1",
        {busy, rsp_valid, rsp_err, mem_req}, 0);
  endtask

  task automatic expect_fill(input string tag, input logic [31:0] va, input logic [19:0] ppn,
                             input int lat, input int mlat);
    bit v, e, m; logic [31:0] d; int c;
    read_op(va, lat, 0, ppn, mlat, 0, v, e, d, c, m);
    chk(v && !e && m, {tag, " fill"}, {v, e, m}, 3'b101);
    chk(d == mem_word(pa_of(ppn, va), salt), "R5", d, mem_word(pa_of(ppn, va), salt));
    chk(c == lat + mlat, "R4", c, lat + mlat);
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] va, input logic [19:0] ppn,
                            input int lat, input logic [31:0] exp_d);
    bit v, e, m; logic [31:0] d; int c;
    read_op(va, lat, 0, ppn, 1, 0, v, e, d, c, m);
    chk(v && !e && !m, {tag, " hit"}, {v, e, m}, 3'b100);
    chk(d == exp_d, tag, d, exp_d);
    chk(c == lat, tag, c, lat);
  endtask

  task automatic expect_fault(input logic [31:0] va, input int lat);
    bit v, e, m; logic [31:0] d; int c;
    read_op(va, lat, 1, 20'h0, 1, 0, v, e, d, c, m);
    chk(!v && e && !m, "R7", {v, e, m}, 3'b010);
    chk(c == lat, "R7", c, lat);
  endtask

  initial begin
    logic [31:0] va_a, va_b, va_c, d_a, d_c;
    va_a = 32'h1234_5a7c;
    va_b = 32'h7777_7a7c;
    va_c = 32'h0040_0104;
    test_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    test_reset();

    // R1 cold miss, fast TLB
    expect_fill("R1", va_a, 20'habcde, 1, 3);
    d_a = mem_word(pa_of(20'habcde, va_a), salt);
    salt = salt ^ 32'h1111_0000;
    // R3 hit after refill returns stored word, not memory
    expect_hit("R3", va_a, 20'habcde, 1, d_a);
    // R9 byte-select bits ignored
    expect_hit("R9", va_a | 32'h3, 20'habcde, 1, d_a);
    // R6 slow TLB, line hits
    expect_hit("R6", va_a, 20'habcde, 5, d_a);
    // R9 other virtual page, same physical page
    expect_hit("R9", va_b, 20'habcde, 1, d_a);
    // R4 same index, other physical page: conflict refill
    expect_fill("R4", va_b, 20'h11111, 1, 2);
    // R5 original mapping now misses again
    expect_fill("R5", va_a, 20'habcde, 1, 1);
    d_a = mem_word(pa_of(20'habcde, va_a), salt);
    // R7 fault leaves a valid line untouched
    expect_fault(va_a, 1);
    salt = salt ^ 32'h0000_2222;
    expect_hit("R7", va_a, 20'habcde, 1, d_a);
    expect_fault(va_c, 3);
    // R6 slow TLB then miss; R7 earlier fault did not fill this line
    expect_fill("R6", va_c, 20'h00777, 3, 1);
    d_c = mem_word(pa_of(20'h00777, va_c), salt);
    // R8 requests held high while busy are not taken
    begin
      bit v, e, m; logic [31:0] d; int c;
      read_op(32'h0900_0abc, 2, 0, 20'h0f0f0, 4, 1, v, e, d, c, m);
      chk(v && m && c == 6, "R8", c, 6);
    end
    expect_hit("R8", va_c, 20'h00777, 1, d_c);
    finish_run();
  end
endmodule